// File: doc/BRIEF.md
# Multicycle Instruction Phase Sequencer

This block is the control unit of a 16-bit processor that takes several clock cycles per instruction. It holds the program counter and the instruction register. It walks every instruction through up to six phases in a fixed order: fetch, decode, address evaluation, operand fetch, execute and result store. Phases that the current opcode does not need are skipped. The arithmetic unit, the register file, the memory and its address and data registers sit outside the block. The block steers all of them through load enables, memory read and write strobes, and one-hot enables that pick which source drives the shared 16-bit bus.

Fetch takes three steps. First the program counter is driven onto the bus and captured as the memory address. Then a read is held until memory signals completion, and the returned word lands in the memory data register. Finally that register is moved over the bus into the instruction register while the program counter advances by one. Any step that involves memory stalls for as long as the memory is busy. A step-enable input stands in for gating the clock. While it is low, nothing inside the block changes and no strobe reaches the outside.

Top module: `insn_sequencer`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, the program counter reads 0x3000 and the block is in the first fetch step. In that step phase is 0, only bus_src bit 0 is set, and mar_ld is high.
- R2: Fetch runs in three steps. Step 1 sets bus_src bit 0 (program counter) and mar_ld. Step 2 holds mem_rd, and raises mdr_ld only in the cycle where mem_ready is high. Step 3 sets bus_src bit 1 (data register), loads the instruction register from the bus and makes the program counter one larger.
- R3: opc_line has exactly one bit set, at the index equal to instruction bits 15:12.
- R4: The phase output encodes fetch=0, decode=1, address=2, operand=3, execute=4, store=5, and phases appear in that order. Opcodes 1, 5 and 9 (operate) run fetch, decode and store. Store in this class sets bus_src bit 2, reg_ld and cc_ld. Opcodes 2, 6, 3 and 7 run fetch, decode, address, operand and store. Opcodes 0 and 12 run fetch, decode and execute. Every other opcode runs fetch and decode only, and decode sets no strobe.
- R5: For opcodes 6, 7 and 12, ea equals base_val plus instruction bits 5:0 sign-extended. For opcodes 0, 2 and 3, ea equals the already incremented program counter plus bits 8:0 sign-extended. In the address phase, bus_src bit 3 and mar_ld are set.
- R6: Loads (opcodes 2 and 6) hold mem_rd in the operand phase until mem_ready, and assert mdr_ld together with mem_ready. Their store phase sets bus_src bit 1, reg_ld and cc_ld.
- R7: Stores (opcodes 3 and 7) set bus_src bit 4 (register file) and mdr_ld in the operand phase. Their store phase holds mem_wr with no bus source until mem_ready is high.
- R8: A branch (opcode 0) is taken when instruction bits 11:9 ANDed with cond_nzp is non-zero. A taken branch sets bus_src bit 3 in execute and loads ea into the program counter. A branch that is not taken drives no bus source and leaves the program counter unchanged.
- R9: A register jump (opcode 12) always sets bus_src bit 3 in execute and loads ea into the program counter.
- R10: bus_src never has more than one bit set.
- R11: While step_en is low, every strobe and bus enable is zero, and state, program counter and instruction register hold their values.
- R12: mem_rd and mem_wr are never high together. Every memory step repeats for as long as mem_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance enable; low freezes the sequencer |
| mem_ready | input | 1 | Memory access completes this cycle |
| bus | input | 16 | Value on the shared bus |
| base_val | input | 16 | Base register value from the register file |
| cond_nzp | input | 3 | Condition codes {n,z,p} |
| bus_src | output | 5 | One-hot bus source: 0 PC, 1 MDR, 2 ALU, 3 address, 4 register |
| mar_ld | output | 1 | Load memory address register from bus |
| mdr_ld | output | 1 | Load memory data register (memory on read, else bus) |
| reg_ld | output | 1 | Write register file from bus |
| cc_ld | output | 1 | Update condition codes |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| pc | output | 16 | Program counter |
| ir | output | 16 | Instruction register |
| ea | output | 16 | Computed address |
| opc_line | output | 16 | One-hot decoded opcode |
| phase | output | 3 | Current phase code |

## Verification
The assertions assume that the surrounding datapath places exactly the selected source on `bus` within the same cycle. In particular, when the address source is chosen, the bus carries `ea`. The bench meets this with a combinational multiplexer that is built only from `bus_src` and its own models of the data register, arithmetic result and register file. `mem_ready` is assumed to matter only while a read or write strobe is up. The bench raises it only during those steps, after 0 to 3 wait cycles, and it inserts random frozen cycles with `step_en` low, some of them in the middle of a memory wait.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int OPC_W   = 4;
    localparam int NUM_OPC = 1 << OPC_W;
    localparam int SRC_PC  = 0;
    localparam int SRC_MDR = 1;
    localparam int SRC_ALU = 2;
    localparam int SRC_EA  = 3;
    localparam int SRC_REG = 4;
    localparam int NUM_SRC = 5;

    typedef enum logic [3:0] {
        ST_F1, ST_F2, ST_F3, ST_DEC, ST_EA, ST_OP, ST_EX, ST_STO
    } seq_state_t;

    typedef enum logic [2:0] {
        PH_FETCH = 3'd0, PH_DECODE = 3'd1, PH_ADDR = 3'd2,
        PH_OPND = 3'd3, PH_EXEC = 3'd4, PH_STORE = 3'd5
    } phase_t;

    typedef enum logic [2:0] {
        CL_NOP, CL_ALU, CL_LDB, CL_LDP, CL_STB, CL_STP, CL_BR, CL_JMP
    } op_class_t;

    typedef struct packed {
        logic [NUM_SRC-1:0] bus_en;
        logic mar_ld;
        logic mdr_ld;
        logic ir_ld;
        logic pc_ld;
        logic pc_inc;
        logic reg_ld;
        logic cc_ld;
        logic mem_rd;
        logic mem_wr;
    } ctrl_t;

    function automatic op_class_t classify(input logic [OPC_W-1:0] opc);
        case (opc)
            4'd1, 4'd5, 4'd9: return CL_ALU;
            4'd6:             return CL_LDB;
            4'd2:             return CL_LDP;
            4'd7:             return CL_STB;
            4'd3:             return CL_STP;
            4'd0:             return CL_BR;
            4'd12:            return CL_JMP;
            default:          return CL_NOP;
        endcase
    endfunction

    function automatic logic uses_base(input op_class_t c);
        return (c == CL_LDB) || (c == CL_STB) || (c == CL_JMP);
    endfunction

    function automatic logic is_store(input op_class_t c);
        return (c == CL_STB) || (c == CL_STP);
    endfunction

    function automatic phase_t phase_of(input seq_state_t s);
        case (s)
            ST_DEC:  return PH_DECODE;
            ST_EA:   return PH_ADDR;
            ST_OP:   return PH_OPND;
            ST_EX:   return PH_EXEC;
            ST_STO:  return PH_STORE;
            default: return PH_FETCH;
        endcase
    endfunction
endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
(
    input  logic [OPC_W-1:0]   opc,
    output logic [NUM_OPC-1:0] opc_line,
    output op_class_t          op_class
);
    for (genvar g = 0; g < NUM_OPC; g++) begin : g_line
        assign opc_line[g] = (opc == OPC_W'(g));
    end

    assign op_class = classify(opc);
endmodule

// File: rtl/seq_addr.sv
module seq_addr #(
    parameter int W     = 16,
    parameter int OFF_B = 6,
    parameter int OFF_P = 9
) (
    input  logic [OFF_P-1:0] off_field,
    input  logic [W-1:0]     pc,
    input  logic [W-1:0]     base_val,
    input  logic             use_base,
    output logic [W-1:0]     ea
);
    logic [W-1:0] off_b_ext;
    logic [W-1:0] off_p_ext;

    assign off_b_ext = {{(W-OFF_B){off_field[OFF_B-1]}}, off_field[OFF_B-1:0]};
    assign off_p_ext = {{(W-OFF_P){off_field[OFF_P-1]}}, off_field};
    assign ea = use_base ? (base_val + off_b_ext) : (pc + off_p_ext);
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       step_en,
    input  logic       mem_ready,
    input  op_class_t  op_class,
    input  logic [2:0] mask,
    input  logic [2:0] nzp,
    output ctrl_t      ctrl,
    output phase_t     phase
);
    seq_state_t state, nxt;
    ctrl_t      c;
    logic       taken;

    assign taken = |(mask & nzp);

    always_comb begin
        c   = '0;
        nxt = state;
        case (state)
            ST_F1: begin
                c.bus_en[SRC_PC] = 1'b1;
                c.mar_ld         = 1'b1;
                nxt              = ST_F2;
            end
            ST_F2: begin
                c.mem_rd = 1'b1;
                c.mdr_ld = mem_ready;
                if (mem_ready) nxt = ST_F3;
            end
            ST_F3: begin
                c.bus_en[SRC_MDR] = 1'b1;
                c.ir_ld           = 1'b1;
                c.pc_inc          = 1'b1;
                nxt               = ST_DEC;
            end
            ST_DEC: begin
                case (op_class)
                    CL_ALU:                         nxt = ST_STO;
                    CL_LDB, CL_LDP, CL_STB, CL_STP: nxt = ST_EA;
                    CL_BR, CL_JMP:                  nxt = ST_EX;
                    default:                        nxt = ST_F1;
                endcase
            end
            ST_EA: begin
                c.bus_en[SRC_EA] = 1'b1;
                c.mar_ld         = 1'b1;
                nxt              = ST_OP;
            end
            ST_OP: begin
                if (is_store(op_class)) begin
                    c.bus_en[SRC_REG] = 1'b1;
                    c.mdr_ld          = 1'b1;
                    nxt               = ST_STO;
                end else begin
                    c.mem_rd = 1'b1;
                    c.mdr_ld = mem_ready;
                    if (mem_ready) nxt = ST_STO;
                end
            end
            ST_EX: begin
                if (op_class == CL_JMP || taken) begin
                    c.bus_en[SRC_EA] = 1'b1;
                    c.pc_ld          = 1'b1;
                end
                nxt = ST_F1;
            end
            ST_STO: begin
                if (is_store(op_class)) begin
                    c.mem_wr = 1'b1;
                    if (mem_ready) nxt = ST_F1;
                end else begin
                    if (op_class == CL_ALU) c.bus_en[SRC_ALU] = 1'b1;
                    else                    c.bus_en[SRC_MDR] = 1'b1;
                    c.reg_ld = 1'b1;
                    c.cc_ld  = 1'b1;
                    nxt      = ST_F1;
                end
            end
            default: nxt = ST_F1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)          state <= ST_F1;
        else if (step_en) state <= nxt;
    end

    assign ctrl  = step_en ? c : '0;
    assign phase = phase_of(state);

    // R12: no simultaneous read and write
    p_rw_excl_r12: assert property (@(posedge clk) disable iff (rst)
        !(ctrl.mem_rd && ctrl.mem_wr));

    // R12: a fetch read without completion repeats
    p_fetch_wait_r12: assert property (@(posedge clk) disable iff (rst)
        (state == ST_F2 && step_en && !mem_ready) |=> state == ST_F2);

    // R4: decode drives no strobe
    p_decode_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DEC) |-> (ctrl == '0));
endmodule

// File: rtl/insn_sequencer.sv
module insn_sequencer
    import seq_pkg::*;
#(
    parameter int          W        = 16,
    parameter int          OFF_B    = 6,
    parameter int          OFF_P    = 9,
    parameter logic [15:0] RESET_PC = 16'h3000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step_en,
    input  logic               mem_ready,
    input  logic [W-1:0]       bus,
    input  logic [W-1:0]       base_val,
    input  logic [2:0]         cond_nzp,
    output logic [NUM_SRC-1:0] bus_src,
    output logic               mar_ld,
    output logic               mdr_ld,
    output logic               reg_ld,
    output logic               cc_ld,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic [W-1:0]       pc,
    output logic [W-1:0]       ir,
    output logic [W-1:0]       ea,
    output logic [NUM_OPC-1:0] opc_line,
    output logic [2:0]         phase
);
    localparam int OPC_LSB = W - OPC_W;
    localparam int MSK_LSB = OPC_LSB - 3;

    ctrl_t     ctrl;
    op_class_t op_class;
    phase_t    phase_e;

    seq_decode u_dec (
        .opc      (ir[W-1:OPC_LSB]),
        .opc_line (opc_line),
        .op_class (op_class)
    );

    seq_addr #(.W(W), .OFF_B(OFF_B), .OFF_P(OFF_P)) u_addr (
        .off_field (ir[OFF_P-1:0]),
        .pc        (pc),
        .base_val  (base_val),
        .use_base  (uses_base(op_class)),
        .ea        (ea)
    );

    seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .step_en   (step_en),
        .mem_ready (mem_ready),
        .op_class  (op_class),
        .mask      (ir[OPC_LSB-1:MSK_LSB]),
        .nzp       (cond_nzp),
        .ctrl      (ctrl),
        .phase     (phase_e)
    );

    always_ff @(posedge clk) begin
        if (rst)               pc <= W'(RESET_PC);
        else if (ctrl.pc_ld)   pc <= bus;
        else if (ctrl.pc_inc)  pc <= pc + W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)              ir <= '0;
        else if (ctrl.ir_ld)  ir <= bus;
    end

    assign bus_src = ctrl.bus_en;
    assign mar_ld  = ctrl.mar_ld;
    assign mdr_ld  = ctrl.mdr_ld;
    assign reg_ld  = ctrl.reg_ld;
    assign cc_ld   = ctrl.cc_ld;
    assign mem_rd  = ctrl.mem_rd;
    assign mem_wr  = ctrl.mem_wr;
    assign phase   = phase_e;

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1: program counter and first step right after reset
    always_ff @(posedge clk) begin
        if (!rst && rst_q)
            p_reset_pc_r1: assert (pc == W'(RESET_PC) && phase_e == PH_FETCH && mar_ld);
    end

    // R10: at most one bus driver
    p_bus_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bus_src));

    // R2: instruction capture advances the program counter by one
    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        ctrl.ir_ld |=> pc == $past(pc) + W'(1));

    // R9: a program counter load takes the computed address off the bus
    p_pc_load_r9: assert property (@(posedge clk) disable iff (rst)
        ctrl.pc_ld |-> bus == ea);

    // R11: frozen cycles change nothing
    p_freeze_r11: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> ($stable(pc) && $stable(ir) && $stable(phase_e)));
endmodule

// File: tb/insn_sequencer_test.sv
`timescale 1ns/1ps
module insn_sequencer_test;
    logic        clk = 1'b0;
    logic        rst, step_en, mem_ready;
    logic [15:0] bus_b, base_val;
    logic [2:0]  cond_nzp;
    logic [4:0]  bus_src;
    logic        mar_ld, mdr_ld, reg_ld, cc_ld, mem_rd, mem_wr;
    logic [15:0] pc, ir, ea, opc_line;
    logic [2:0]  phase;

    logic [15:0] mar_m, mdr_m, rd_data, alu_val, reg_val, wr_addr, wr_data;
    logic [15:0] pc_exp;
    int vectors = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    insn_sequencer uut (
        .clk(clk), .rst(rst), .step_en(step_en), .mem_ready(mem_ready),
        .bus(bus_b), .base_val(base_val), .cond_nzp(cond_nzp),
        .bus_src(bus_src), .mar_ld(mar_ld), .mdr_ld(mdr_ld), .reg_ld(reg_ld),
        .cc_ld(cc_ld), .mem_rd(mem_rd), .mem_wr(mem_wr), .pc(pc), .ir(ir),
        .ea(ea), .opc_line(opc_line), .phase(phase)
    );

    always_comb
        bus_b = ({16{bus_src[0]}} & pc) | ({16{bus_src[1]}} & mdr_m) |
                ({16{bus_src[2]}} & alu_val) | ({16{bus_src[3]}} & ea) |
                ({16{bus_src[4]}} & reg_val);

    always_ff @(posedge clk) begin
        if (mar_ld) mar_m <= bus_b;
        if (mdr_ld) mdr_m <= mem_rd ? rd_data : bus_b;
        if (mem_wr && mem_ready) begin
            wr_addr <= mar_m;
            wr_data <= mdr_m;
        end
    end

    function automatic int cls(input logic [3:0] op);
        case (op)
            4'd1, 4'd5, 4'd9: return 1;
            4'd6: return 2;
            4'd2: return 3;
            4'd7: return 4;
            4'd3: return 5;
            4'd0: return 6;
            4'd12: return 7;
            default: return 0;
        endcase
    endfunction

    function automatic logic [15:0] exp_ea(input logic [15:0] w, input logic [15:0] pcn,
                                           input logic [15:0] base);
        int c = cls(w[15:12]);
        if (c == 2 || c == 4 || c == 7) return base + {{10{w[5]}}, w[5:0]};
        return pcn + {{7{w[8]}}, w[8:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_ctl(input string tag, input logic [2:0] ph, input logic [4:0] bs,
                           input logic [5:0] ctl);
        logic [13:0] obs, exv;
        obs = {phase, bus_src, mar_ld, mdr_ld, reg_ld, cc_ld, mem_rd, mem_wr};
        exv = {ph, bs, ctl};
        chk(obs == exv, tag, 32'(obs), 32'(exv));
    endtask

    // one cycle forward, sometimes with a frozen cycle first (R11)
    task automatic adv();
        if (($urandom % 8) == 0) begin
            logic [2:0]  ph0 = phase;
            logic [15:0] pc0 = pc, ir0 = ir;
            step_en = 1'b0;
            #1;
            chk_ctl("R11 strobes off while frozen", ph0, 5'b0, 6'b0);
            @(posedge clk);
            @(negedge clk);
            chk(phase == ph0 && pc == pc0 && ir == ir0, "R11 state held",
                {pc, ir}, {pc0, ir0});
            step_en = 1'b1;
            #1;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic mem_wait(input string tag, input logic [2:0] ph, input int lat,
                            input bit wr);
        for (int i = 0; i < lat; i++) begin
            mem_ready = 1'b0;
            #1;
            chk_ctl(tag, ph, 5'b0, wr ? 6'b000001 : 6'b000010);
            adv();
        end
        mem_ready = 1'b1;
        #1;
        chk_ctl(tag, ph, 5'b0, wr ? 6'b000001 : 6'b010010);
        adv();
        mem_ready = 1'b0;
    endtask

    task automatic run_insn(input logic [15:0] w, input int lat, input logic [2:0] nzp);
        logic [15:0] pe = pc_exp;
        logic [15:0] ee;
        int c = cls(w[15:12]);
        base_val = 16'($urandom);
        reg_val  = 16'($urandom);
        alu_val  = 16'($urandom);
        cond_nzp = nzp;
        rd_data  = w;
        #1;
        chk_ctl("R2 fetch step1", 3'd0, 5'b00001, 6'b100000);
        chk(pc == pe, "R2 pc at fetch", 32'(pc), 32'(pe));
        adv();
        chk(mar_m == pe, "R2 address captured", 32'(mar_m), 32'(pe));
        mem_wait("R2 R12 fetch read", 3'd0, lat, 1'b0);
        chk_ctl("R2 fetch step3", 3'd0, 5'b00010, 6'b0);
        adv();
        chk_ctl("R4 decode", 3'd1, 5'b0, 6'b0);
        chk(ir == w, "R2 instruction loaded", 32'(ir), 32'(w));
        chk(pc == pe + 16'd1, "R2 pc incremented", 32'(pc), 32'(pe + 16'd1));
        chk(opc_line == (16'd1 << w[15:12]), "R3 opcode line", 32'(opc_line),
            32'(16'd1 << w[15:12]));
        ee = exp_ea(w, pe + 16'd1, base_val);
        pc_exp = pe + 16'd1;
        adv();
        case (c)
            1: begin
                chk_ctl("R4 operate store", 3'd5, 5'b00100, 6'b001100);
                adv();
            end
            2, 3, 4, 5: begin
                chk_ctl("R5 address phase", 3'd2, 5'b01000, 6'b100000);
                chk(ea == ee, "R5 address value", 32'(ea), 32'(ee));
                adv();
                chk(mar_m == ee, "R5 address captured", 32'(mar_m), 32'(ee));
                if (c == 2 || c == 3) begin
                    mem_wait("R6 R12 load read", 3'd3, lat, 1'b0);
                    chk_ctl("R6 load store", 3'd5, 5'b00010, 6'b001100);
                    adv();
                end else begin
                    chk_ctl("R7 store operand", 3'd3, 5'b10000, 6'b010000);
                    adv();
                    mem_wait("R7 R12 store write", 3'd5, lat, 1'b1);
                    chk(wr_addr == ee && wr_data == reg_val, "R7 write content",
                        {wr_addr, wr_data}, {ee, reg_val});
                end
            end
            6: begin
                bit tk = |(w[11:9] & nzp);
                chk_ctl("R8 branch execute", 3'd4, tk ? 5'b01000 : 5'b0, 6'b0);
                if (tk) pc_exp = ee;
                adv();
                chk(pc == pc_exp, "R8 branch target", 32'(pc), 32'(pc_exp));
            end
            7: begin
                chk_ctl("R9 jump execute", 3'd4, 5'b01000, 6'b0);
                chk(ea == ee, "R9 jump address", 32'(ea), 32'(ee));
                pc_exp = ee;
                adv();
                chk(pc == pc_exp, "R9 jump target", 32'(pc), 32'(pc_exp));
            end
            default: ;
        endcase
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; step_en = 1'b1; mem_ready = 1'b0;
        base_val = '0; cond_nzp = '0; alu_val = '0; reg_val = '0; rd_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pc == 16'h3000, "R1 reset pc", 32'(pc), 32'h3000);
        rst = 1'b0;
        #1;
        chk_ctl("R1 first fetch step", 3'd0, 5'b00001, 6'b100000);
        pc_exp = 16'h3000;
        // directed corners
        run_insn(16'h1283, 0, 3'b001);          // operate
        run_insn(16'hD000, 1, 3'b010);          // unused opcode: fetch+decode only (R4)
        run_insn(16'h0E05, 0, 3'b100);          // branch mask 111 taken (R8)
        run_insn(16'h01FF, 2, 3'b111);          // branch mask 000 never taken (R8)
        run_insn(16'h0A10, 0, 3'b010);          // mask 101 vs z: not taken (R8)
        run_insn(16'h2500, 3, 3'b000);          // load pc-rel, offset -256 (R5 R6)
        run_insn(16'h6660, 0, 3'b000);          // load base, offset -32 (R5 R6)
        run_insn(16'h7A1F, 3, 3'b000);          // store base, offset +31 (R7)
        run_insn(16'h30FF, 0, 3'b000);          // store pc-rel (R7)
        run_insn(16'hC0E0, 1, 3'b000);          // register jump negative offset (R9)
        for (int n = 0; n < 400; n++)
            run_insn(16'($urandom), int'($urandom % 4), 3'($urandom));
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule